// File: doc/BRIEF.md
# SD card SPI boot and single-block read engine

This block talks to an SD card in SPI mode. When reset is released it starts the card on its own. It holds chip select high and sends a run of idle clocks at a reduced SPI clock rate. It then issues the software reset command (CMD0), followed by the initialisation command (CMD1), which it repeats until the card reports that it has left the idle state. Once the card is up, the block switches its SPI clock to half the system clock and raises `ready`.

After that, a one-cycle request with a 32-bit byte address starts a single-block read (CMD17). The block polls for the card's one-byte reply and waits for the start token. It then passes the 512 data bytes out one by one, each with a valid strobe. The two trailing CRC bytes are clocked in and dropped. Completion is signalled by `done`, and `error` rises in the same cycle if the card refused the read or stayed silent. Every transaction closes with chip select high and eight extra clocks.

Top module: `sd_spi_engine`

## Requirements
- R1: While reset is held and right after it, `spi_cs_n` is 1, `spi_sclk` is 0 and `ready`, `data_valid`, `done` and `error` are 0.
- R2: Before chip select first goes low, the block gives at least 74 rising SCLK edges with chip select high and MOSI at 1.
- R3: Before `ready`, every SCLK high phase lasts SLOW_DIV system cycles. From `ready` on, it lasts one cycle, so the SPI clock is half the system clock.
- R4: A command is six bytes sent MSB first. Byte 0 is binary 01 followed by the 6-bit index. Bytes 1 to 4 hold the argument, most significant byte first. Byte 5 is 0x95 for index 0 and 0xFF otherwise. The argument is 0 for indices 0 and 1.
- R5: Boot sends index 0 once and then index 1 until its reply equals 0x00. `ready` then rises and stays high.
- R6: A `rd_req` pulse while `ready` is high and `busy` is low sends index 17 with `rd_addr` as its argument. The block waits for reply 0x00 and token 0xFE and then outputs 512 bytes in card order on `data_byte` with `data_valid`. It then pulses `done` with `error` low and `busy` low.
- R7: A good read drives `data_valid` exactly 512 times. Its transaction holds chip select low for 6 command bytes, the reply and token polls, 512 data bytes and exactly 2 CRC bytes.
- R8: Each transaction ends with chip select rising, followed by exactly 8 rising SCLK edges before the next falling edge of chip select.
- R9: Reply bytes equal to 0xFF are skipped. A nonzero reply to index 17 ends the read with `done` and `error` and no data. So does a reply still absent after 8 poll bytes, which leaves the transaction 14 bytes long.
- R10: `rd_req` and `rd_addr` have no effect while `busy` is high. A request held high in the cycle `done` pulses is taken on the next clock edge, so `busy` is high one cycle later.
- R11: MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Pulse that starts a block read |
| rd_addr | input | 32 | Byte address of the block |
| ready | output | 1 | Card booted, reads accepted |
| busy | output | 1 | Boot or read in progress |
| data_byte | output | 8 | Received data byte |
| data_valid | output | 1 | `data_byte` holds a new byte |
| done | output | 1 | Read finished (one cycle) |
| error | output | 1 | Read failed, valid with `done` |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Data to card |
| spi_miso | input | 1 | Data from card |
| spi_cs_n | output | 1 | Card chip select, active low |

## Verification
The end of one read and the start of the next can fall in adjacent cycles. The bench holds `rd_req` high through a read, with a different address driven mid-transfer. The read must ignore both. The held request must then be taken in the cycle right after `done`, which shows as `busy` high one clock later and a second CMD17 frame carrying the new address. A bench SD card model decodes every frame, answers from queues and compares each data byte in the cycle its strobe is seen.

// File: rtl/sd_spi_pkg.sv
package sd_spi_pkg;
  typedef enum logic [3:0] {
    ST_PWR, ST_CMD, ST_RESP, ST_TOKEN, ST_DATA, ST_CRC, ST_TAIL, ST_IDLE, ST_FAIL
  } sd_st_e;

  localparam logic [5:0] IDX_RESET = 6'd0;
  localparam logic [5:0] IDX_INIT  = 6'd1;
  localparam logic [5:0] IDX_READ  = 6'd17;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] TOKEN_BYTE = 8'hFE;
  localparam logic [7:0] RESET_CRC = 8'h95;
  localparam int BLOCK_BYTES = 512;
  localparam int FRAME_BYTES = 6;
  localparam int POLL_BYTES  = 8;
endpackage

// File: rtl/sd_spi_tick.sv
module sd_spi_tick #(
  parameter int SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int CW = $clog2(SLOW_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (fast_i || (cnt_q == CW'(SLOW_DIV - 1)));

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    if (!run_i || tick_o) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (SLOW_DIV > 1) begin : g_gap
      // R3: in slow mode two ticks are never back to back
      p_slow_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_i && $past(tick_o) && $past(run_i) && $past(!fast_i)) |-> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/sd_spi_byte.sv
module sd_spi_byte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       tick_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  logic       busy_q, busy_d, ph_q, ph_d, done_q, done_d;
  logic [7:0] tx_q, tx_d, rx_q, rx_d;
  logic [2:0] bit_q, bit_d;

  always_comb begin
    busy_d = busy_q; ph_d = ph_q; tx_d = tx_q; rx_d = rx_q;
    bit_d = bit_q; done_d = 1'b0;
    if (!busy_q) begin
      if (go_i) begin
        busy_d = 1'b1; tx_d = tx_i; bit_d = '0; ph_d = 1'b0;
      end
    end else if (tick_i) begin
      if (!ph_q) begin
        ph_d = 1'b1;
        rx_d = {rx_q[6:0], miso_i};
      end else begin
        ph_d  = 1'b0;
        tx_d  = {tx_q[6:0], 1'b1};
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          busy_d = 1'b0; done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; ph_q <= 1'b0; done_q <= 1'b0;
      tx_q <= '1; rx_q <= '1; bit_q <= '0;
    end else begin
      busy_q <= busy_d; ph_q <= ph_d; done_q <= done_d;
      tx_q <= tx_d; rx_q <= rx_d; bit_q <= bit_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = ph_q;
  assign mosi_o = busy_q ? tx_q[7] : 1'b1;

  // R11: data towards the card holds still across a high clock phase
  p_mosi_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
endmodule

// File: rtl/sd_spi_engine.sv
module sd_spi_engine
  import sd_spi_pkg::*;
#(
  parameter int SLOW_DIV    = 8,
  parameter int PWR_BYTES   = 10,
  parameter int TOKEN_TRIES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic [31:0] rd_addr,
  output logic        ready,
  output logic        busy,
  output logic [7:0]  data_byte,
  output logic        data_valid,
  output logic        done,
  output logic        error,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  localparam int CNT_LIM = (TOKEN_TRIES > BLOCK_BYTES) ? TOKEN_TRIES : BLOCK_BYTES;
  localparam int CNT_W   = $clog2(CNT_LIM + PWR_BYTES + 1);

  sd_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [5:0]  idx_q, idx_d;
  logic [31:0] addr_q, addr_d;
  logic fast_q, fast_d, ok_q, ok_d, bad_q, bad_d;
  logic dv_q, dv_d, done_q, done_d, err_q, err_d;
  logic [7:0] db_q, db_d;

  logic tick, eng_busy, eng_done, go;
  logic [7:0] tx_byte, rx_byte;
  logic [31:0] arg;

  sd_spi_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(eng_busy), .fast_i(fast_q), .tick_o(tick));

  sd_spi_byte u_byte (
    .clk(clk), .rst_n(rst_n), .go_i(go), .tx_i(tx_byte), .tick_i(tick),
    .miso_i(spi_miso), .busy_o(eng_busy), .done_o(eng_done), .rx_o(rx_byte),
    .sclk_o(spi_sclk), .mosi_o(spi_mosi));

  assign arg = (idx_q == IDX_READ) ? addr_q : 32'd0;
  assign go  = (st_q != ST_IDLE) && (st_q != ST_FAIL) && !eng_busy && !eng_done;

  always_comb begin
    tx_byte = FILL_BYTE;
    if (st_q == ST_CMD) begin
      case (cnt_q)
        CNT_W'(0): tx_byte = {2'b01, idx_q};
        CNT_W'(1): tx_byte = arg[31:24];
        CNT_W'(2): tx_byte = arg[23:16];
        CNT_W'(3): tx_byte = arg[15:8];
        CNT_W'(4): tx_byte = arg[7:0];
        default:   tx_byte = (idx_q == IDX_RESET) ? RESET_CRC : FILL_BYTE;
      endcase
    end
  end

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q; addr_d = addr_q;
    fast_d = fast_q; ok_d = ok_q; bad_d = bad_q;
    dv_d = 1'b0; done_d = 1'b0; err_d = 1'b0; db_d = db_q;
    if (st_q == ST_IDLE) begin
      if (rd_req) begin
        st_d = ST_CMD; cnt_d = '0; idx_d = IDX_READ; addr_d = rd_addr; bad_d = 1'b0;
      end
    end else if (eng_done) begin
      cnt_d = cnt_q + CNT_W'(1);
      case (st_q)
        ST_PWR: if (cnt_q == CNT_W'(PWR_BYTES - 1)) begin
          st_d = ST_CMD; cnt_d = '0; idx_d = IDX_RESET;
        end
        ST_CMD: if (cnt_q == CNT_W'(FRAME_BYTES - 1)) begin
          st_d = ST_RESP; cnt_d = '0;
        end
        ST_RESP: if (rx_byte != FILL_BYTE) begin
          cnt_d = '0;
          st_d  = ST_TAIL;
          if (idx_q == IDX_RESET) begin
            if (rx_byte != 8'h01) st_d = ST_FAIL;
          end else if (idx_q == IDX_INIT) begin
            if (rx_byte == 8'h00) ok_d = 1'b1;
            else if (rx_byte != 8'h01) st_d = ST_FAIL;
          end else if (rx_byte == 8'h00) st_d = ST_TOKEN;
          else bad_d = 1'b1;
        end else if (cnt_q == CNT_W'(POLL_BYTES - 1)) begin
          st_d  = (idx_q == IDX_READ) ? ST_TAIL : ST_FAIL;
          bad_d = 1'b1;
        end
        ST_TOKEN: if (rx_byte == TOKEN_BYTE) begin
          st_d = ST_DATA; cnt_d = '0;
        end else if (rx_byte != FILL_BYTE || cnt_q == CNT_W'(TOKEN_TRIES - 1)) begin
          st_d = ST_TAIL; bad_d = 1'b1;
        end
        ST_DATA: begin
          dv_d = 1'b1; db_d = rx_byte;
          if (cnt_q == CNT_W'(BLOCK_BYTES - 1)) begin
            st_d = ST_CRC; cnt_d = '0;
          end
        end
        ST_CRC: if (cnt_q == CNT_W'(1)) st_d = ST_TAIL;
        ST_TAIL: begin
          cnt_d = '0;
          if (idx_q == IDX_RESET) begin
            st_d = ST_CMD; idx_d = IDX_INIT;
          end else if (idx_q == IDX_INIT) begin
            st_d = ok_q ? ST_IDLE : ST_CMD;
            fast_d = ok_q;
          end else begin
            st_d = ST_IDLE; done_d = 1'b1; err_d = bad_q;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_PWR; cnt_q <= '0; idx_q <= IDX_RESET; addr_q <= '0;
      fast_q <= 1'b0; ok_q <= 1'b0; bad_q <= 1'b0;
      dv_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; db_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; addr_q <= addr_d;
      fast_q <= fast_d; ok_q <= ok_d; bad_q <= bad_d;
      dv_q <= dv_d; done_q <= done_d; err_q <= err_d; db_q <= db_d;
    end
  end

  assign ready      = fast_q;
  assign busy       = (st_q != ST_IDLE);
  assign data_byte  = db_q;
  assign data_valid = dv_q;
  assign done       = done_q;
  assign error      = err_q;
  assign spi_cs_n   = !((st_q == ST_CMD) || (st_q == ST_RESP) || (st_q == ST_TOKEN) ||
                        (st_q == ST_DATA) || (st_q == ST_CRC));

  // R6: completion is only reported once the block is free again
  p_done_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9: a failure flag never appears without completion
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
  // R7: data strobes come only out of the data phase
  p_valid_in_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> ($past(st_q) == ST_DATA));
  // R5: once up, the card stays up
  p_ready_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready) |-> ready);
  // R8: the card is deselected whenever the block waits for work
  p_cs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> spi_cs_n);
endmodule

// File: tb/sd_spi_engine_test.sv
module sd_spi_engine_test;
  localparam int SLOW_DIV = 8;

  logic clk, rst_n, rd_req, spi_miso;
  logic [31:0] rd_addr;
  logic ready, busy, data_valid, done, error, spi_sclk, spi_mosi, spi_cs_n;
  logic [7:0] data_byte;

  sd_spi_engine #(.SLOW_DIV(SLOW_DIV), .PWR_BYTES(10), .TOKEN_TRIES(256)) uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .ready(ready),
    .busy(busy), .data_byte(data_byte), .data_valid(data_valid), .done(done),
    .error(error), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- card model ----------------
  logic [7:0] rsp_q[$];
  logic [7:0] exp_q[$];
  logic [5:0] log_idx[$];
  logic [31:0] log_arg[$];
  logic [7:0] log_crc[$];
  logic [7:0] fr[6];
  int fr_n = 0, nb = 0, init_busy_left = 2, read_mode = 0;
  int txn_bytes = 0, last_txn = 0;
  logic [7:0] in_sh, out_sh;
  bit first_sel = 1;
  int hi_rises = 0, pre_rises = 0, r8_bad = 0, r8_seen = 0;
  bit pre_mosi_ok = 1;

  function automatic logic [7:0] pat(input logic [31:0] a, input int i);
    return 8'(a[7:0] + 8'(i * 7) + 8'(i >> 8));
  endfunction

  task automatic card_byte(input logic [7:0] b);
    txn_bytes++;
    if (fr_n == 0 && b[7:6] != 2'b01) return;
    fr[fr_n] = b; fr_n++;
    if (fr_n < 6) return;
    fr_n = 0;
    log_idx.push_back(fr[0][5:0]);
    log_arg.push_back({fr[1], fr[2], fr[3], fr[4]});
    log_crc.push_back(fr[5]);
    case (fr[0][5:0])
      6'd0: begin rsp_q.push_back(8'hFF); rsp_q.push_back(8'h01); end
      6'd1: begin
        rsp_q.push_back(8'hFF);
        rsp_q.push_back(init_busy_left > 0 ? 8'h01 : 8'h00);
        if (init_busy_left > 0) init_busy_left--;
      end
      6'd17: begin
        if (read_mode == 0) begin
          rsp_q.push_back(8'hFF); rsp_q.push_back(8'h00);
          rsp_q.push_back(8'hFF); rsp_q.push_back(8'hFF); rsp_q.push_back(8'hFE);
          for (int i = 0; i < 512; i++) begin
            rsp_q.push_back(pat({fr[1], fr[2], fr[3], fr[4]}, i));
            exp_q.push_back(pat({fr[1], fr[2], fr[3], fr[4]}, i));
          end
          rsp_q.push_back(8'hA5); rsp_q.push_back(8'h5A);
        end else if (read_mode == 1) begin
          rsp_q.push_back(8'hFF); rsp_q.push_back(8'h05);
        end
      end
      default: ;
    endcase
  endtask

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      in_sh = {in_sh[6:0], spi_mosi};
      nb++;
      if (nb == 8) begin nb = 0; card_byte(in_sh); end
    end else begin
      hi_rises++;
      if (first_sel && !spi_mosi) pre_mosi_ok = 0;
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (nb == 0) out_sh = (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'hFF;
      else out_sh = {out_sh[6:0], 1'b1};
      spi_miso = out_sh[7];
    end
  end

  always @(posedge spi_cs_n) begin
    nb = 0; fr_n = 0; rsp_q.delete(); out_sh = 8'hFF; spi_miso = 1'b1;
    last_txn = txn_bytes; txn_bytes = 0; hi_rises = 0;
  end

  always @(negedge spi_cs_n) begin
    if (first_sel) pre_rises = hi_rises;
    else begin r8_seen++; if (hi_rises != 8) r8_bad++; end
    first_sel = 0; hi_rises = 0; txn_bytes = 0;
  end

  // ---------------- per-clock monitors ----------------
  int hi_len = 0, slow_bad = 0, slow_seen = 0, fast_bad = 0, fast_seen = 0;
  int mode0_bad = 0, dv_count = 0;
  logic prev_sclk = 1'b0, prev_mosi = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_sclk) hi_len++;
      else if (prev_sclk) begin
        if (ready) begin fast_seen++; if (hi_len != 1) fast_bad++; end
        else begin slow_seen++; if (hi_len != SLOW_DIV) slow_bad++; end
        hi_len = 0;
      end
      if (spi_sclk && prev_sclk && spi_mosi != prev_mosi) mode0_bad++;
      if (data_valid) begin
        dv_count++;
        if (exp_q.size() == 0) chk(0, "R6 unexpected data", data_byte, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(data_byte == e, "R6 data byte", data_byte, e);
        end
      end
    end
    prev_sclk = spi_sclk; prev_mosi = spi_mosi;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(0, "watchdog", cyc, 190000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_done(output bit ok);
    int t = 0;
    ok = 0;
    while (t < 40000) begin
      @(negedge clk);
      if (done) begin ok = 1; return; end
      t++;
    end
  endtask

  task automatic read_blk(input logic [31:0] a, input int mode, output bit ok);
    read_mode = mode;
    @(negedge clk);
    rd_addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    wait_done(ok);
  endtask

  initial begin
    bit ok;
    int n17, dv0;
    rst_n = 1'b0; rd_req = 1'b0; rd_addr = '0; spi_miso = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n && !spi_sclk, "R1 bus idle", {spi_cs_n, spi_sclk}, 2'b10);
    chk(!ready && !data_valid && !done && !error, "R1 flags low",
        {ready, data_valid, done, error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n && !ready, "R1 after release", {spi_cs_n, ready}, 2'b10);

    begin
      int t = 0;
      while (!ready && t < 60000) begin @(negedge clk); t++; end
    end
    chk(ready, "R5 ready after boot", ready, 1);
    chk(pre_rises >= 74 && pre_mosi_ok, "R2 power-up clocks", pre_rises, 74);
    chk(log_idx.size() == 4, "R5 boot command count", log_idx.size(), 4);
    if (log_idx.size() == 4) begin
      chk(log_idx[0] == 0 && log_arg[0] == 0, "R5 first is reset", log_idx[0], 0);
      chk(log_crc[0] == 8'h95, "R4 reset check byte", log_crc[0], 8'h95);
      for (int k = 1; k < 4; k++) begin
        chk(log_idx[k] == 1 && log_arg[k] == 0, "R5 init repeated", log_idx[k], 1);
        chk(log_crc[k] == 8'hFF, "R4 init check byte", log_crc[k], 8'hFF);
      end
    end
    chk(slow_bad == 0 && slow_seen > 0, "R3 slow clock", slow_bad, 0);

    // good read
    read_blk(32'h0000_1234, 0, ok);
    chk(ok && !error && !busy, "R6 read A done", {ok, error, busy}, 3'b100);
    chk(log_idx[$] == 17 && log_arg[$] == 32'h0000_1234, "R4 read frame", log_arg[$], 32'h1234);
    chk(log_crc[$] == 8'hFF, "R4 read check byte", log_crc[$], 8'hFF);
    @(negedge clk);
    chk(dv_count == 512 && exp_q.size() == 0, "R7 byte count", dv_count, 512);
    chk(last_txn == 525, "R7 transaction length", last_txn, 525);

    // R10: request and address ignored while busy; held request taken after done
    n17 = log_idx.size();
    read_mode = 0;
    @(negedge clk);
    rd_addr = 32'h00AB_CDEF; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    repeat (200) @(negedge clk);
    rd_addr = 32'h0000_0777; rd_req = 1'b1;
    wait_done(ok);
    chk(ok && !error, "R10 read B done", {ok, error}, 2'b10);
    chk(log_idx.size() == n17 + 1 && log_arg[$] == 32'h00AB_CDEF, "R10 addr ignored",
        log_arg[$], 32'h00AB_CDEF);
    @(negedge clk);
    chk(busy, "R10 held request taken next cycle", busy, 1);
    rd_req = 1'b0;
    wait_done(ok);
    chk(ok && !error && log_arg[$] == 32'h0000_0777, "R10 read C", log_arg[$], 32'h777);

    // R9 refused read
    dv0 = dv_count;
    read_blk(32'h0000_2000, 1, ok);
    chk(ok && error, "R9 refused read error", {ok, error}, 2'b11);
    @(negedge clk);
    chk(dv_count == dv0, "R9 no data on refusal", dv_count, dv0);

    // R9 silent card
    read_blk(32'h0000_3000, 2, ok);
    chk(ok && error, "R9 timeout error", {ok, error}, 2'b11);
    @(negedge clk);
    chk(last_txn == 14 && dv_count == dv0, "R9 poll limit", last_txn, 14);

    // recovery and top address
    read_blk(32'hFFFF_FFFF, 0, ok);
    chk(ok && !error && log_arg[$] == 32'hFFFF_FFFF, "R6 read after errors", log_arg[$], 32'hFFFF_FFFF);
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all bytes seen", exp_q.size(), 0);
    chk(fast_bad == 0 && fast_seen > 0, "R3 fast clock", fast_bad, 0);
    chk(r8_bad == 0 && r8_seen > 0, "R8 trailing clocks", r8_bad, 0);
    chk(mode0_bad == 0, "R11 mosi stable while high", mode0_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule